// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter built from 4-bit stages that all change on the rising clock edge. An active-low clear and an active-low parallel load act only at the edge, and two count-enable inputs must both be high for the counter to advance. The clear has the highest priority, then the load, then counting, then holding the present value.

The stages are chained with look-ahead carry. Each stage's terminal-count signal is high when its carry-enable is high and the stage holds all ones. That signal feeds the carry-enable of the next stage, so the whole chain counts as one binary number. The top terminal-count output follows the carry-enable input combinationally, so a further counter outside the block can be cascaded onto it.

A non-zero `MODULUS` parameter adds a decode of the final count `MODULUS-1` onto the synchronous clear. The counter then returns to zero on the edge after it reaches that count. Registers hold an unknown value until the first clear.

Top module: `casc_count`

## Requirements
- R1: With `clr_n` low at a rising edge, `q` becomes 0 at that edge, whatever `load_n`, `cnt_en` and `carry_en` are.
- R2: With `clr_n` high and `load_n` low at a rising edge, `q` takes the value of `din` at that edge, whatever the levels of both enables.
- R3: With `clr_n` and `load_n` high and both `cnt_en` and `carry_en` high at a rising edge, `q` increments by one.
- R4: With `clr_n` and `load_n` high and either enable low at a rising edge, `q` keeps its value.
- R5: `tc` is high exactly when `carry_en` is high and `q` is all ones, and it follows `carry_en` without a clock edge.
- R6: Counting from the all-ones value wraps to 0.
- R7: With `STAGES` above 1, a stage above the lowest advances only when every stage below it holds 1111 and both enables are high, so the full `q` counts as one binary number.
- R8: With `MODULUS` non-zero, a count of `MODULUS-1` is followed by 0 at the next edge, whatever the load and enable inputs are.
- R9: The sequence clear, load 12, then six counting edges gives 0, 12, 13, 14, 15, 0, 1, 2, and with counting inhibited afterwards the value stays at 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable to every stage |
| carry_en | input | 1 | Carry enable into the lowest stage, also gates `tc` |
| din | input | 4*STAGES | Parallel load data |
| q | output | 4*STAGES | Counter value |
| tc | output | 1 | Terminal count of the top stage |

## Verification
The bench builds three copies that receive the same stimulus. The first uses the default of one stage with the natural modulus and covers the reference sequence and all sixteen combinations of clear, load and both enables. The second uses two stages, so the carry can ripple from the low nibble into the high one and the wrap at 8'hFF can be reached. The third uses one stage with `MODULUS` 11, so the bench can check that the decoded clear takes priority over load and enables at count 10.

// File: rtl/casc_count.sv
module casc_count #(
  parameter int STAGES  = 1,
  parameter int MODULUS = 0,
  localparam int W      = 4 * STAGES
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         cnt_en,
  input  logic         carry_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         tc
);

  logic              clr_eff;
  logic [STAGES:0]   cet;
  logic [STAGES-1:0] tcs;

  assign cet[0] = carry_en;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [3:0] qs;

    always_ff @(posedge clk) begin
      if (!clr_eff)                qs <= 4'd0;
      else if (!load_n)            qs <= din[4*i +: 4];
      else if (cnt_en && cet[i])   qs <= qs + 4'd1;
    end

    assign tcs[i]     = cet[i] & (&qs);
    assign cet[i+1]   = tcs[i];
    assign q[4*i +: 4] = qs;
  end

  assign tc = tcs[STAGES-1];

  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  if (MODULUS > 0) begin : g_mod
    localparam logic [W-1:0] LAST = W'(MODULUS - 1);
    assign clr_eff = clr_n & (q != LAST);

    a_r8_mod_wrap: assert property (@(posedge clk) disable iff (!started)
      q == LAST |=> q == '0);
  end else begin : g_nomod
    assign clr_eff = clr_n;
  end

  a_r1_clear: assert property (@(posedge clk) disable iff (!started)
    !clr_n |=> q == '0);

  a_r2_load: assert property (@(posedge clk) disable iff (!started)
    clr_eff && !load_n |=> q == $past(din));

  a_r3_count: assert property (@(posedge clk) disable iff (!started)
    clr_eff && load_n && cnt_en && carry_en |=> q == $past(q) + W'(1));

  a_r4_hold: assert property (@(posedge clk) disable iff (!started)
    clr_eff && load_n && !(cnt_en && carry_en) |=> $stable(q));

  a_r5_tc: assert property (@(posedge clk) disable iff (!started)
    tc == (carry_en && (&q)));

endmodule

// File: tb/test_casc_count.sv
module test_casc_count;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       clr_n = 1'b1, load_n = 1'b1, cnt_en = 1'b0, carry_en = 1'b0;
  logic [7:0] din = 8'h00;
  logic [3:0] q4, q11;
  logic [7:0] q8;
  logic       tc4, tc8, tc11;
  logic [7:0] e4, e8, e11;
  int checks = 0, fails = 0;

  casc_count i_casc_count (.clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
    .carry_en(carry_en), .din(din[3:0]), .q(q4), .tc(tc4));
  casc_count #(.STAGES(2)) i_casc_count_w8 (.clk(clk), .clr_n(clr_n), .load_n(load_n),
    .cnt_en(cnt_en), .carry_en(carry_en), .din(din), .q(q8), .tc(tc8));
  casc_count #(.MODULUS(11)) i_casc_count_m11 (.clk(clk), .clr_n(clr_n), .load_n(load_n),
    .cnt_en(cnt_en), .carry_en(carry_en), .din(din[3:0]), .q(q11), .tc(tc11));

  function automatic logic [7:0] model(input logic [7:0] cur, input int w, input int m);
    logic [7:0] mask = (w == 8) ? 8'hFF : 8'h0F;
    if (m > 0 && cur == 8'(m - 1)) return 8'h00;
    if (!clr_n)                    return 8'h00;
    if (!load_n)                   return din & mask;
    if (cnt_en && carry_en)        return (cur + 8'd1) & mask;
    return cur;
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "q4", {4'h0, q4}, e4);
    chk(tag, "q8", q8, e8);
    chk(tag, "q11", {4'h0, q11}, e11);
    chk(tag, "tc4", {7'h0, tc4}, {7'h0, carry_en && e4 == 8'h0F});
    chk(tag, "tc8", {7'h0, tc8}, {7'h0, carry_en && e8 == 8'hFF});
    chk(tag, "tc11", {7'h0, tc11}, {7'h0, carry_en && e11 == 8'h0F});
  endtask

  task automatic tick(input string tag);
    e4 = model(e4, 4, 0);
    e8 = model(e8, 8, 0);
    e11 = model(e11, 4, 11);
    @(posedge clk); #1;
    check_all(tag);
  endtask

  task automatic drive(input logic c, input logic l, input logic e, input logic t, input logic [7:0] d);
    clr_n = c; load_n = l; cnt_en = e; carry_en = t; din = d;
  endtask

  task automatic t_clear_r1;
    drive(0, 0, 1, 1, 8'hA5);
    e4 = 8'h00; e8 = 8'h00; e11 = 8'h00;
    @(posedge clk); #1;
    check_all("R1");
    drive(0, 1, 0, 0, 8'h00);
    tick("R1");
  endtask

  task automatic t_ref_seq_r9;
    drive(0, 1, 0, 0, 8'h00); tick("R9");
    drive(1, 0, 0, 0, 8'h0C); tick("R9");
    drive(1, 1, 1, 1, 8'h00);
    for (int k = 0; k < 6; k++) tick("R9");
    chk("R9", "seq end", {4'h0, q4}, 8'h02);
    drive(1, 1, 0, 1, 8'h00);
    for (int k = 0; k < 3; k++) tick("R9");
    chk("R9", "inhibit", {4'h0, q4}, 8'h02);
  endtask

  task automatic t_load_r2;
    for (int k = 0; k < 4; k++) begin
      drive(1, 0, k[0], k[1], 8'h37 + 8'(k * 8'h29));
      tick("R2");
    end
  endtask

  task automatic t_hold_r4;
    drive(1, 0, 0, 0, 8'h5A); tick("R4");
    drive(1, 1, 1, 0, 8'h00); tick("R4"); tick("R4");
    drive(1, 1, 0, 1, 8'h00); tick("R4"); tick("R4");
    drive(1, 1, 0, 0, 8'h00); tick("R4");
  endtask

  task automatic t_combos_r3;
    for (int k = 0; k < 16; k++) begin
      drive(1, 0, 0, 0, 8'h06); tick("R3");
      drive(k[3], k[2], k[1], k[0], 8'h93);
      tick("R3");
    end
  endtask

  task automatic t_tc_r5;
    drive(1, 0, 0, 0, 8'hFF); tick("R5");
    drive(1, 1, 0, 1, 8'hFF); #1;
    chk("R5", "tc rise no clk", {7'h0, tc4}, 8'h01);
    chk("R5", "tc8 rise no clk", {7'h0, tc8}, 8'h01);
    carry_en = 1'b0; #1;
    chk("R5", "tc fall no clk", {7'h0, tc4}, 8'h00);
    chk("R5", "tc8 fall no clk", {7'h0, tc8}, 8'h00);
  endtask

  task automatic t_wrap_r6;
    drive(1, 0, 0, 0, 8'hFE); tick("R6");
    drive(1, 1, 1, 1, 8'h00); tick("R6"); tick("R6");
    chk("R6", "wrap4", {4'h0, q4}, 8'h00);
    chk("R6", "wrap8", q8, 8'h00);
  endtask

  task automatic t_cascade_r7;
    drive(1, 0, 0, 0, 8'h1D); tick("R7");
    drive(1, 1, 1, 1, 8'h00);
    for (int k = 0; k < 5; k++) tick("R7");
    chk("R7", "carry across nibble", q8, 8'h22);
    drive(1, 0, 0, 0, 8'h2F); tick("R7");
    drive(1, 1, 1, 0, 8'h00); tick("R7");
    chk("R7", "no carry when cet low", q8, 8'h2F);
  endtask

  task automatic t_modulo_r8;
    drive(0, 1, 0, 0, 8'h00); tick("R8");
    drive(1, 1, 1, 1, 8'h00);
    for (int k = 0; k < 13; k++) tick("R8");
    chk("R8", "mod11 after 13", {4'h0, q11}, 8'h02);
    drive(1, 0, 0, 0, 8'h0A); tick("R8");
    drive(1, 0, 0, 0, 8'h07); tick("R8");
    chk("R8", "decoded clear beats load", {4'h0, q11}, 8'h00);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    t_clear_r1;
    t_ref_seq_r9;
    t_load_r2;
    t_hold_r4;
    t_combos_r3;
    t_tc_r5;
    t_wrap_r6;
    t_cascade_r7;
    t_modulo_r8;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule